// File: doc/BRIEF.md
# Heater PWM Controller with Thermal Cutoff

This block drives a set of heater enables for a thermal test module. Each heater channel has its own 8-bit duty value. All channels share one 8-bit phase counter, which advances once every `PRESCALE` clocks. A channel is on while the phase is below its duty value. The heaters run only while the module reports high-power mode.

A protection guard watches a signed 16-bit temperature sample with 1/256 °C resolution. The sample is taken only when its valid strobe is high. When a sample reaches the cutoff temperature, the guard silences every heater and raises a status bit. The heaters are released again once a sample has dropped 5 °C below the cutoff. The cutoff setting is an 8-bit whole-degree value, and it is limited to 100 °C. The guard only gates the outputs and never touches the duty inputs, so the heaters come back at their earlier duty values.

After reset the heaters stay off until the first valid temperature sample has been judged.

Top module: `heater_pwm_ctrl`

## Requirements
- R1: Channel `ch` takes its duty from `duty_i[ch*8 +: 8]`. While the guard is running and `hp_mode_i` is high, channel `ch` is on for exactly duty×`PRESCALE` clocks in every window of 256×`PRESCALE` consecutive clocks. With the default `PRESCALE` = 4, duty 0x10 gives 64, duty 0x80 gives 512 and duty 0xFF gives 1020. A duty of 0 keeps the channel off.
- R2: While `hp_mode_i` is low, every bit of `heat_en_o` is 0 from the clock edge that samples it, whatever the duty values are.
- R3: A `cutoff_i` value above 100 behaves exactly as 100.
- R4: A valid sample with `temp_i` ≥ cutoff×256 (signed compare) sets `cutoff_act_o` at the edge that samples it. All heater enables are then 0 from the following edge.
- R5: While `cutoff_act_o` is high, a valid sample with `temp_i` ≤ (cutoff−5)×256 clears it. A valid sample strictly between the two thresholds leaves it set. The subtraction is signed, so a cutoff below 5 gives a negative release level.
- R6: After a release, each channel returns to the on-count given by its unchanged duty input.
- R7: While `temp_vld_i` is low, `temp_i` has no effect on `cutoff_act_o` or on the heaters.
- R8: After a synchronous reset, `cutoff_act_o` is 0 and all heaters stay off until the first valid sample. That first sample either starts the heaters or trips the guard directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hp_mode_i | input | 1 | High-power mode indication |
| duty_i | input | NUM_CH*8 | Packed duty values; channel ch in bits ch*8 +: 8 |
| cutoff_i | input | 8 | Cutoff temperature, 1 °C per LSB |
| temp_i | input | 16 | Signed temperature, 1/256 °C per LSB |
| temp_vld_i | input | 1 | Temperature sample strobe |
| heat_en_o | output | NUM_CH | Heater PWM enables |
| cutoff_act_o | output | 1 | Cutoff active status |

## Verification
A valid temperature sample is judged at the edge that samples it. `cutoff_act_o` is therefore due one edge after the strobe is driven, and the heater enables follow one edge later. A drop of `hp_mode_i` or a duty of 0 reaches `heat_en_o` after a single edge. Inputs are driven on the falling clock and outputs are read on the falling clock after the due edge. Duty is measured by counting on-cycles over a full 256×`PRESCALE` window that begins only after the enables have settled. The count then does not depend on where the phase counter stood when the window started.

// File: rtl/heater_pkg.sv
package heater_pkg;

    localparam int DUTY_W    = 8;
    localparam int TEMP_W    = 16;
    localparam int CUT_W     = 8;
    localparam int FRAC_BITS = 8;
    localparam int CUT_MAX   = 100;
    localparam int HYST_DEG  = 5;

    typedef enum logic [1:0] {
        GUARD_WAIT = 2'd0,
        GUARD_RUN  = 2'd1,
        GUARD_TRIP = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic signed [TEMP_W:0] trip_lvl;
        logic signed [TEMP_W:0] rel_lvl;
    } guard_thr_t;

    function automatic logic [CUT_W-1:0] clamp_cut(input logic [CUT_W-1:0] c);
        if (c > CUT_W'(CUT_MAX)) return CUT_W'(CUT_MAX);
        return c;
    endfunction

    function automatic guard_thr_t make_thr(input logic [CUT_W-1:0] c);
        guard_thr_t t;
        logic signed [TEMP_W:0] deg;
        logic signed [TEMP_W:0] low_deg;
        deg        = signed'((TEMP_W+1)'(clamp_cut(c)));
        low_deg    = deg - signed'((TEMP_W+1)'(HYST_DEG));
        t.trip_lvl = deg <<< FRAC_BITS;
        t.rel_lvl  = low_deg <<< FRAC_BITS;
        return t;
    endfunction

endpackage

// File: rtl/heater_phase_gen.sv
module heater_phase_gen
    import heater_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DUTY_W-1:0] phase_o
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic tick;

    generate
        if (PRESCALE == 1) begin : g_no_div
            assign tick = 1'b1;
        end else begin : g_div
            logic [PS_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else if (pre_q == PS_W'(PRESCALE - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = (pre_q == PS_W'(PRESCALE - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
        end else if (tick) begin
            phase_o <= phase_o + 1'b1;
        end
    end

endmodule

// File: rtl/heater_trip_guard.sv
module heater_trip_guard
    import heater_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CUT_W-1:0]         cutoff_i,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic                     temp_vld_i,
    output guard_state_e             state_o
);
    guard_thr_t             thr;
    logic signed [TEMP_W:0] temp_x;
    logic                   hot;
    logic                   cool;
    guard_state_e           state_q;
    guard_state_e           state_d;

    always_comb begin
        thr    = make_thr(cutoff_i);
        temp_x = TEMP_W'(temp_i);
        temp_x = {temp_i[TEMP_W-1], temp_i};
        hot    = (temp_x >= thr.trip_lvl);
        cool   = (temp_x <= thr.rel_lvl);
    end

    always_comb begin
        state_d = state_q;
        if (temp_vld_i) begin
            unique case (state_q)
                GUARD_WAIT: state_d = hot ? GUARD_TRIP : GUARD_RUN;
                GUARD_RUN:  if (hot)  state_d = GUARD_TRIP;
                GUARD_TRIP: if (cool) state_d = GUARD_RUN;
                default:    state_d = GUARD_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GUARD_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/heater_pwm_lane.sv
module heater_pwm_lane
    import heater_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              allow_i,
    input  logic [DUTY_W-1:0] phase_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              en_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= 1'b0;
        end else begin
            en_o <= allow_i && (phase_i < duty_i);
        end
    end

endmodule

// File: rtl/heater_pwm_ctrl.sv
module heater_pwm_ctrl
    import heater_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int PRESCALE = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hp_mode_i,
    input  logic [NUM_CH*DUTY_W-1:0]   duty_i,
    input  logic [CUT_W-1:0]           cutoff_i,
    input  logic signed [TEMP_W-1:0]   temp_i,
    input  logic                       temp_vld_i,
    output logic [NUM_CH-1:0]          heat_en_o,
    output logic                       cutoff_act_o
);
    logic [DUTY_W-1:0] phase;
    guard_state_e      gstate;
    logic              allow;

    heater_phase_gen #(.PRESCALE(PRESCALE)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    heater_trip_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .cutoff_i   (cutoff_i),
        .temp_i     (temp_i),
        .temp_vld_i (temp_vld_i),
        .state_o    (gstate)
    );

    assign allow        = hp_mode_i && (gstate == GUARD_RUN);
    assign cutoff_act_o = (gstate == GUARD_TRIP);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
            heater_pwm_lane u_lane (
                .clk     (clk),
                .rst     (rst),
                .allow_i (allow),
                .phase_i (phase),
                .duty_i  (duty_i[ch*DUTY_W +: DUTY_W]),
                .en_o    (heat_en_o[ch])
            );
        end
    endgenerate

endmodule

// File: rtl/heater_pwm_ctrl_chk.sv
module heater_pwm_ctrl_chk
    import heater_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     hp_mode_i,
    input logic [NUM_CH*DUTY_W-1:0] duty_i,
    input logic [CUT_W-1:0]         cutoff_i,
    input logic signed [TEMP_W-1:0] temp_i,
    input logic                     temp_vld_i,
    input logic [NUM_CH-1:0]        heat_en_o,
    input logic                     cutoff_act_o
);
    int   cut_deg;
    int   trip_ref;
    int   rel_ref;
    int   temp_ref;
    logic seen_q;

    always_comb begin
        cut_deg  = (int'(cutoff_i) > 100) ? 100 : int'(cutoff_i);
        trip_ref = cut_deg * 256;
        rel_ref  = (cut_deg - 5) * 256;
        temp_ref = int'(temp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (temp_vld_i) seen_q <= 1'b1;
    end

    // R2: low-power mode silences every heater
    assert_lowpwr_off_R2: assert property (@(posedge clk) disable iff (rst)
        !hp_mode_i |=> (heat_en_o == '0));

    // R4 and R3: a sample at or above the clamped cutoff trips the guard
    assert_trip_R4: assert property (@(posedge clk) disable iff (rst)
        (temp_vld_i && temp_ref >= trip_ref) |=> cutoff_act_o);

    // R4: a tripped guard keeps the heaters off
    assert_trip_gate_R4: assert property (@(posedge clk) disable iff (rst)
        cutoff_act_o |=> (heat_en_o == '0));

    // R5: a sample at or below the release level clears the trip
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (cutoff_act_o && temp_vld_i && temp_ref <= rel_ref) |=> !cutoff_act_o);

    // R5: a sample between the levels holds the trip
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cutoff_act_o && temp_vld_i && temp_ref > rel_ref) |=> cutoff_act_o);

    // R7: no strobe, no change of the status
    assert_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !temp_vld_i |=> $stable(cutoff_act_o));

    // R8: heaters stay off until a first sample has been seen
    assert_wait_first_R8: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (heat_en_o == '0));

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
            // R1: duty zero keeps the channel off
            assert_zero_duty_R1: assert property (@(posedge clk) disable iff (rst)
                (duty_i[ch*DUTY_W +: DUTY_W] == '0) |=> !heat_en_o[ch]);
        end
    endgenerate

endmodule

bind heater_pwm_ctrl heater_pwm_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hp_mode_i    (hp_mode_i),
    .duty_i       (duty_i),
    .cutoff_i     (cutoff_i),
    .temp_i       (temp_i),
    .temp_vld_i   (temp_vld_i),
    .heat_en_o    (heat_en_o),
    .cutoff_act_o (cutoff_act_o)
);

// File: tb/heater_pwm_ctrl_bench.sv
module heater_pwm_ctrl_bench;
    localparam int NUM_CH   = 4;
    localparam int PRESCALE = 4;
    localparam int WIN      = 256 * PRESCALE;
    localparam int NVEC     = 16;

    // fields: cutoff[24:17], temp[16:1], expected status[0]
    localparam logic [24:0] VEC [NVEC] = '{
        {8'd100, 16'h1400, 1'b0},
        {8'd100, 16'h63FF, 1'b0},
        {8'd100, 16'h6400, 1'b1},
        {8'd100, 16'h5F01, 1'b1},
        {8'd100, 16'h5F00, 1'b0},
        {8'd100, 16'h7530, 1'b1},
        {8'd100, 16'hF600, 1'b0},
        {8'd200, 16'h6400, 1'b1},
        {8'd200, 16'h5F01, 1'b1},
        {8'd200, 16'h5F00, 1'b0},
        {8'd50,  16'h3200, 1'b1},
        {8'd50,  16'h2D01, 1'b1},
        {8'd50,  16'h2D00, 1'b0},
        {8'd3,   16'h0300, 1'b1},
        {8'd3,   16'hFE01, 1'b1},
        {8'd3,   16'hFE00, 1'b0}
    };

    localparam int EXP_ON [NUM_CH] = '{64, 512, 1020, 0};

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     hp_mode_i;
    logic [NUM_CH*8-1:0]      duty_i;
    logic [7:0]               cutoff_i;
    logic signed [15:0]       temp_i;
    logic                     temp_vld_i;
    logic [NUM_CH-1:0]        heat_en_o;
    logic                     cutoff_act_o;

    int checks = 0;
    int fails  = 0;
    int cnt [NUM_CH];
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    heater_pwm_ctrl #(.NUM_CH(NUM_CH), .PRESCALE(PRESCALE)) u_heater_pwm_ctrl (
        .clk          (clk),
        .rst          (rst),
        .hp_mode_i    (hp_mode_i),
        .duty_i       (duty_i),
        .cutoff_i     (cutoff_i),
        .temp_i       (temp_i),
        .temp_vld_i   (temp_vld_i),
        .heat_en_o    (heat_en_o),
        .cutoff_act_o (cutoff_act_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample(input logic [7:0] cut, input logic [15:0] t);
        @(negedge clk);
        cutoff_i   = cut;
        temp_i     = t;
        temp_vld_i = 1'b1;
        @(negedge clk);
        temp_vld_i = 1'b0;
    endtask

    task automatic count_window();
        for (int c = 0; c < NUM_CH; c++) cnt[c] = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            for (int c = 0; c < NUM_CH; c++) cnt[c] += int'(heat_en_o[c]);
        end
    endtask

    task automatic check_counts(input string tag, input bit running);
        count_window();
        for (int c = 0; c < NUM_CH; c++)
            check($sformatf("%s ch%0d on-count", tag, c), cnt[c], running ? EXP_ON[c] : 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        rst        = 1'b1;
        hp_mode_i  = 1'b1;
        duty_i     = {8'h00, 8'hFF, 8'h80, 8'h10};
        cutoff_i   = 8'd100;
        temp_i     = '0;
        temp_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state and silence before the first sample
        @(negedge clk);
        check("R8 status after reset", int'(cutoff_act_o), 0);
        check_counts("R8 before first sample", 1'b0);

        // Vector walk: R1 R3 R4 R5 R6 (first entry also covers R8)
        for (int v = 0; v < NVEC; v++) begin
            sample(VEC[v][24:17], VEC[v][16:1]);
            check($sformatf("R4 R5 R3 vector %0d status", v), int'(cutoff_act_o), int'(VEC[v][0]));
            check_counts($sformatf("R1 R6 vector %0d", v), !VEC[v][0]);
        end

        // R2: low-power mode, one-edge latency then whole window
        @(negedge clk);
        hp_mode_i = 1'b0;
        @(negedge clk);
        check("R2 heaters off one edge after low-power", int'(heat_en_o), 0);
        check_counts("R2 low-power window", 1'b0);
        hp_mode_i = 1'b1;
        @(negedge clk);
        check_counts("R6 R1 back in high-power", 1'b1);

        // R4: latency of the trip to status and to heaters
        sample(8'd100, 16'h6400);
        check("R4 status at sampling edge", int'(cutoff_act_o), 1);
        @(negedge clk);
        check("R4 heaters off edge after", int'(heat_en_o), 0);

        // R7: temperature without strobe is ignored
        sample(8'd100, 16'h1400);
        check("R7 released before strobe test", int'(cutoff_act_o), 0);
        @(negedge clk);
        temp_i = 16'h7530;
        repeat (10) @(negedge clk);
        check("R7 no strobe keeps status", int'(cutoff_act_o), 0);
        check_counts("R7 no strobe keeps heaters", 1'b1);

        // R8: reset while tripped, then first sample trips directly
        sample(8'd100, 16'h7000);
        check("R8 tripped before reset", int'(cutoff_act_o), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 status cleared by reset", int'(cutoff_act_o), 0);
        check("R8 heaters off after reset", int'(heat_en_o), 0);
        sample(8'd100, 16'h6500);
        check("R8 first sample trips directly", int'(cutoff_act_o), 1);
        check_counts("R8 tripped first sample", 1'b0);

        finish_run();
    end

endmodule